// File: doc/BRIEF.md
# CAN Controller Interrupt Generation Unit

This block turns the status levels and event strobes of a CAN protocol controller core into one active-low interrupt request for the CPU. A CPU-writable enable register chooses which sources may interrupt. Each enabled source sets a bit in an interrupt flag register. The CPU reads the flag register to find the cause. Bit timing, frame handling, error counters and the status register belong to the controller core and reach this block only as input signals.

Two kinds of source are handled differently. The receive source follows the receive-buffer-full level: while the buffer is full and the receive enable is set, flag bit 0 is set. It is never cleared by a read, and it drops as soon as its enable is cleared. All other sources are sticky. Each is latched when its event happens while its enable is set, and it stays set until the CPU reads the flag register. The two error-state sources fire on a change in either direction: the bus-status and error-status bits for the warning source, and the error-passive state for the passive source. Each change is found by comparing the current input with a registered copy of its value from the previous cycle.

Access goes through a simple synchronous port. A write takes effect at the clock edge on which it is sampled. A read returns its data one cycle later, on a registered output.

Top module: `can_irq_unit`

## Requirements
- R1: The enable register is at address 1 and resets to 0. Writes store bits 7:0, except bit 4. A read of address 1 returns the stored bits, with bit 4 and bits 31:8 always 0.
- R2: Flag and enable bits share positions: 0 receive, 1 transmit, 2 error warning, 3 data overrun, 5 error passive, 6 arbitration lost, 7 bus error, 4 reserved and always 0. The flag register is read at address 0. Read data appears on `reg_rdata` in the cycle after `reg_rd` is sampled. Reads of any other address return 0.
- R3: Flag bit 0 is set while `rx_full` is 1 and enable bit 0 is 1. A read does not clear it.
- R4: When enable bit 0 is written to 0 and no other flag is set, `irq_n` is high right after that write's clock edge.
- R5: Flag bit 3 is set on a 0-to-1 transition of `overrun`. A level that stays high does not set it again.
- R6: Flag bit 2 is set when `bus_off` or `err_warn` changes value, in either direction.
- R7: Flag bit 5 is set when `err_passive` changes value, in either direction.
- R8: Flag bit 1 is set by a `tx_done` pulse or by a 0-to-1 transition of `tx_buf_free`.
- R9: A one-cycle pulse on `arb_lost` sets flag bit 6. A one-cycle pulse on `bus_err` sets flag bit 7.
- R10: An event that occurs while its enable bit is 0 sets no flag. Setting the enable bit afterwards does not raise the interrupt for that event.
- R11: A read of address 0 returns the flags as they were before the clock edge of the read, and clears flag bits 7:1 at that edge. An event in the same cycle as the read leaves its flag set.
- R12: `irq_n` is 0 exactly when at least one flag bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register address: 0 is flags, 1 is enable |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data; only the writable bits are carried |
| reg_rdata | output | 32 | Registered read data |
| rx_full | input | 1 | Receive buffer full (level) |
| overrun | input | 1 | Data overrun status (level) |
| bus_off | input | 1 | Bus status bit (level) |
| err_warn | input | 1 | Error status bit (level) |
| err_passive | input | 1 | Controller is error passive (level) |
| tx_done | input | 1 | Transmission completed (one-cycle pulse) |
| tx_buf_free | input | 1 | Transmit buffer accessible (level) |
| arb_lost | input | 1 | Arbitration lost (one-cycle pulse) |
| bus_err | input | 1 | Bus error detected (one-cycle pulse) |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach from the ports is an event arriving in the same cycle as a clearing read of the flag register. In that cycle the read must return the old flags, while the set path wins over the clear path. The stimulus raises `reg_rd` and an arbitration-lost pulse on the same falling edge. The bench then expects a zero read followed by a read that shows the flag. The bench also walks each error-state input both up and down, with a read between the two changes, so both directions of change detection are seen separately. It holds `overrun` and `tx_buf_free` high across a clearing read to show that a steady level does not set the flag again.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
    localparam int DATA_W  = 32;
    localparam int EN_W    = 8;
    localparam int ADDR_W  = 2;

    localparam int BIT_RX  = 0;
    localparam int BIT_TX  = 1;
    localparam int BIT_EW  = 2;
    localparam int BIT_OV  = 3;
    localparam int BIT_RSV = 4;
    localparam int BIT_EP  = 5;
    localparam int BIT_AL  = 6;
    localparam int BIT_BE  = 7;

    localparam logic [EN_W-1:0] EN_MASK = 8'hEF;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_FLAGS  = 2'd0,
        ADDR_ENABLE = 2'd1
    } reg_addr_e;
endpackage

// File: rtl/can_irq_enable_reg.sv
module can_irq_enable_reg
    import can_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [EN_W-1:0] wr_data,
    output logic [EN_W-1:0] en_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en) begin
            en_q <= wr_data & EN_MASK;
        end
    end

    // R1: a write stores its data with the reserved bit forced low
    a_r1_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en_q == ($past(wr_data) & EN_MASK)));
    a_r1_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[BIT_RSV]);
endmodule

// File: rtl/can_irq_event_det.sv
module can_irq_event_det
    import can_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_full,
    input  logic            overrun,
    input  logic            bus_off,
    input  logic            err_warn,
    input  logic            err_passive,
    input  logic            tx_done,
    input  logic            tx_buf_free,
    input  logic            arb_lost,
    input  logic            bus_err,
    output logic [EN_W-1:0] evt
);
    logic ov_q, bo_q, ew_q, ep_q, tbf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ov_q  <= 1'b0;
            bo_q  <= 1'b0;
            ew_q  <= 1'b0;
            ep_q  <= 1'b0;
            tbf_q <= 1'b0;
        end else begin
            ov_q  <= overrun;
            bo_q  <= bus_off;
            ew_q  <= err_warn;
            ep_q  <= err_passive;
            tbf_q <= tx_buf_free;
        end
    end

    always_comb begin
        evt          = '0;
        evt[BIT_RX]  = rx_full;
        evt[BIT_TX]  = tx_done | (tx_buf_free & ~tbf_q);
        evt[BIT_EW]  = (bus_off ^ bo_q) | (err_warn ^ ew_q);
        evt[BIT_OV]  = overrun & ~ov_q;
        evt[BIT_EP]  = err_passive ^ ep_q;
        evt[BIT_AL]  = arb_lost;
        evt[BIT_BE]  = bus_err;
    end

    // R5: a level held high gives no second overrun event
    a_r5_overrun_once: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && ov_q) |-> !evt[BIT_OV]);
    // R7: a steady passive state gives no event
    a_r7_passive_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (err_passive == ep_q) |-> !evt[BIT_EP]);
endmodule

// File: rtl/can_irq_flag_reg.sv
module can_irq_flag_reg
    import can_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EN_W-1:0] evt,
    input  logic [EN_W-1:0] en,
    input  logic            clr,
    output logic [EN_W-1:0] flags
);
    for (genvar i = 0; i < EN_W; i++) begin : g_bit
        if (i == BIT_RX) begin : g_level
            assign flags[i] = evt[i] & en[i];
        end else begin : g_sticky
            logic flag_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flag_q <= 1'b0;
                end else if (evt[i] && en[i]) begin
                    flag_q <= 1'b1;
                end else if (clr) begin
                    flag_q <= 1'b0;
                end
            end
            assign flags[i] = flag_q;

            // R10: an enabled event is always latched
            a_r10_enabled_latch: assert property (@(posedge clk) disable iff (!rst_n)
                (evt[i] && en[i]) |=> flags[i]);
            // R11: a set flag holds until a clearing read
            a_r11_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (flags[i] && !clr) |=> flags[i]);
            // R10: a disabled event does not set a clear flag
            a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                (!flags[i] && !en[i]) |=> !flags[i]);
        end
    end

    // R11: a read with no new event clears every sticky flag
    a_r11_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && ((evt & en) == '0)) |=> (flags[EN_W-1:1] == '0));
endmodule

// File: rtl/can_irq_unit.sv
module can_irq_unit
    import can_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [EN_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rx_full,
    input  logic              overrun,
    input  logic              bus_off,
    input  logic              err_warn,
    input  logic              err_passive,
    input  logic              tx_done,
    input  logic              tx_buf_free,
    input  logic              arb_lost,
    input  logic              bus_err,
    output logic              irq_n
);
    localparam int PAD_W = DATA_W - EN_W;

    logic [EN_W-1:0] en_q;
    logic [EN_W-1:0] evt;
    logic [EN_W-1:0] flags;
    logic            en_wr;
    logic            flag_clr;
    logic [EN_W-1:0] rd_mux;

    assign en_wr    = reg_wr && (reg_addr == ADDR_ENABLE);
    assign flag_clr = reg_rd && (reg_addr == ADDR_FLAGS);

    can_irq_enable_reg u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (en_wr),
        .wr_data (reg_wdata),
        .en_q    (en_q)
    );

    can_irq_event_det u_det (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_full     (rx_full),
        .overrun     (overrun),
        .bus_off     (bus_off),
        .err_warn    (err_warn),
        .err_passive (err_passive),
        .tx_done     (tx_done),
        .tx_buf_free (tx_buf_free),
        .arb_lost    (arb_lost),
        .bus_err     (bus_err),
        .evt         (evt)
    );

    can_irq_flag_reg u_flg (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .en    (en_q),
        .clr   (flag_clr),
        .flags (flags)
    );

    always_comb begin
        unique case (reg_addr)
            ADDR_FLAGS:  rd_mux = flags;
            ADDR_ENABLE: rd_mux = en_q;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= {{PAD_W{1'b0}}, rd_mux};
        end
    end

    assign irq_n = ~|flags;

    // R4: clearing the receive enable with nothing else pending releases the line
    a_r4_rx_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(en_q[BIT_RX]) && (flags[EN_W-1:1] == '0)) |-> irq_n);
    // R1: reserved read bits stay zero
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[DATA_W-1:EN_W] == '0) && !reg_rdata[BIT_RSV]);
    // R3: the receive flag follows its level input while enabled
    a_r3_rx_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && en_q[BIT_RX]) |-> !irq_n);
endmodule

// File: tb/tb_can_irq_unit.sv
module tb_can_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  reg_addr;
    logic        reg_wr, reg_rd;
    logic [7:0]  reg_wdata;
    logic [31:0] reg_rdata;
    logic rx_full, overrun, bus_off, err_warn, err_passive;
    logic tx_done, tx_buf_free, arb_lost, bus_err;
    logic irq_n;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        mon_rd;

    always #2.5 clk = ~clk;

    can_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_full(rx_full), .overrun(overrun), .bus_off(bus_off),
        .err_warn(err_warn), .err_passive(err_passive), .tx_done(tx_done),
        .tx_buf_free(tx_buf_free), .arb_lost(arb_lost), .bus_err(bus_err),
        .irq_n(irq_n)
    );

    // monitor: pops an expected read value one step after each sampled read
    always @(posedge clk) begin
        mon_rd = reg_rd && rst_n;
        #1;
        if (mon_rd && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (reg_rdata !== e) begin
                errors++;
                $display("FAIL %s: rdata actual %h expected %h", t, reg_rdata, e);
            end
        end
    end

    task automatic chk_irq(input logic exp, input string tag);
        checks++;
        if (irq_n !== exp) begin
            errors++;
            $display("FAIL %s: irq_n actual %b expected %b", tag, irq_n, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_addr = '0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
        rx_full = 0; overrun = 0; bus_off = 0; err_warn = 0; err_passive = 0;
        tx_done = 0; tx_buf_free = 0; arb_lost = 0; bus_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_irq(1'b1, "R12 reset");
        rd(2'd0, 32'h0, "R2 reset flags");
        rd(2'd1, 32'h0, "R1 reset enable");
        rd(2'd2, 32'h0, "R2 unmapped");

        wr(2'd1, 8'hFF);
        rd(2'd1, 32'h0000_00EF, "R1 masked enable");

        // R10: disabled events stay silent, enabling later does not raise
        wr(2'd1, 8'h00);
        step; arb_lost = 1; step; arb_lost = 0;
        chk_irq(1'b1, "R10 disabled arb");
        wr(2'd1, 8'hEF);
        chk_irq(1'b1, "R10 enable after");
        rd(2'd0, 32'h0, "R10 flags empty");

        // R3 / R4 receive level
        step; rx_full = 1; step;
        chk_irq(1'b0, "R3 rx level");
        rd(2'd0, 32'h01, "R3 rx flag");
        rd(2'd0, 32'h01, "R3 rx not cleared");
        wr(2'd1, 8'hEE);
        chk_irq(1'b1, "R4 rx disable");
        wr(2'd1, 8'hEF);
        chk_irq(1'b0, "R3 rx reenable");
        rx_full = 0; step;
        chk_irq(1'b1, "R3 rx drop");

        // R5 overrun rising edge only
        overrun = 1; step;
        chk_irq(1'b0, "R5 overrun");
        rd(2'd0, 32'h08, "R5 overrun flag");
        rd(2'd0, 32'h00, "R5 steady level");
        overrun = 0; step;

        // R6 warning in both directions, both inputs
        bus_off = 1; step; rd(2'd0, 32'h04, "R6 bus_off up");
        bus_off = 0; step; rd(2'd0, 32'h04, "R6 bus_off down");
        err_warn = 1; step; rd(2'd0, 32'h04, "R6 err_warn up");
        err_warn = 0; step; rd(2'd0, 32'h04, "R6 err_warn down");

        // R7 passive both directions
        err_passive = 1; step; rd(2'd0, 32'h20, "R7 passive up");
        err_passive = 0; step; rd(2'd0, 32'h20, "R7 passive down");

        // R8 transmit
        tx_done = 1; step; tx_done = 0;
        rd(2'd0, 32'h02, "R8 tx done");
        tx_buf_free = 1; step;
        rd(2'd0, 32'h02, "R8 buffer free");
        rd(2'd0, 32'h00, "R8 buffer steady");
        tx_buf_free = 0; step;
        rd(2'd0, 32'h00, "R8 buffer fall");

        // R9 / R12 arbitration and bus error
        arb_lost = 1; step; arb_lost = 0;
        rd(2'd0, 32'h40, "R9 arb lost");
        bus_err = 1; step; bus_err = 0;
        chk_irq(1'b0, "R12 pending");
        rd(2'd0, 32'h80, "R9 bus err");
        chk_irq(1'b1, "R12 after clear");

        // R11 event during clearing read
        @(negedge clk);
        reg_addr = 2'd0; reg_rd = 1; arb_lost = 1;
        exp_q.push_back(32'h0); tag_q.push_back("R11 same cycle read");
        @(negedge clk);
        reg_rd = 0; arb_lost = 0;
        chk_irq(1'b0, "R11 flag kept");
        rd(2'd0, 32'h40, "R11 flag kept read");

        repeat (3) step;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule